// File: doc/BRIEF.md
# Servo Mode Hysteresis Filter

This block decides which of two disc-motor control modes is active and holds that choice in a single flag. A high flag selects the coarse pre-servo mode. A low flag selects the fine main-servo mode. Once per frame a strobe arrives together with a lock status bit, which is low while the frame synchroniser is running, tracking is engaged and the data stream is phase locked. The block counts how many consecutive frames have shown the same lock level. It moves the flag only after an unbroken run of the length that applies to the direction of the change.

The thresholds are asymmetric. The flag falls to main mode after a short run of locked frames, 16 by default. It climbs back to pre-servo mode only after a longer run of unlocked frames, 64 by default. This keeps short dropouts from throwing the motor back into coarse control. A host command strobe overrides the filter: it toggles the flag at once and restarts both runs. A parameter lets the command input be treated either as a one-cycle strobe or as a level whose rising edge counts as the command.

Top module: `srv_mode_hyst`

## Requirements
- R1: After reset the mode flag is high (pre-servo) and both run counts are zero.
- R2: While the flag is high, it goes low on the clock edge that samples the ENTER_RUN-th consecutive frame strobe with lock status low (default 16). After only ENTER_RUN-1 such frames it is still high.
- R3: While the flag is low, it goes high on the clock edge that samples the LEAVE_RUN-th consecutive frame strobe with lock status high (default 64). After LEAVE_RUN-1 such frames it is still low.
- R4: A frame strobe whose lock level differs from the current run clears that run's count, so the full run length must then be observed again from zero.
- R5: Run counts and the mode flag change only on a cycle with a frame strobe or a command. The lock status level is ignored in cycles without a strobe.
- R6: A command toggles the flag on the next clock edge, takes priority over a frame strobe in the same cycle (that frame is not counted), and clears both run counts.
- R7: Run counts saturate at their threshold, so an arbitrarily long run never wraps and never causes a spurious mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe, once per frame |
| lock_n | input | 1 | Lock status for this frame, low when locked |
| host_cmd | input | 1 | Mode-change command from the host |
| mode_pre | output | 1 | High for pre-servo mode, low for main-servo mode |

## Verification
The hardest case is a command that lands in the same cycle as a frame strobe partway through a run. The run must be discarded and that frame left uncounted, which is only visible later, when the threshold is reached one frame further out than it would otherwise be. The stimulus builds partial runs of known length, fires the command on a strobe cycle, and then counts frames up to one short of the threshold and to the threshold itself. Saturation is reached with runs several times longer than the threshold, each followed by an opposite run of exact length.

// File: rtl/srv_mode_pkg.sv
package srv_mode_pkg;

   typedef enum logic {
      MODE_MAIN = 1'b0,
      MODE_PRE  = 1'b1
   } srv_mode_e;

   localparam srv_mode_e RESET_MODE = MODE_PRE;

   function automatic srv_mode_e mode_flip(input srv_mode_e m);
      return (m == MODE_PRE) ? MODE_MAIN : MODE_PRE;
   endfunction

endpackage

// File: rtl/srv_run_cnt.sv
module srv_run_cnt #(
   parameter int unsigned RUN_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last_step
);
   localparam int unsigned CW = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN);
   localparam logic [CW-1:0] CNT_NEAR = CW'(RUN_LEN - 1);

   if (RUN_LEN < 1) begin : g_bad_len
      $error("srv_run_cnt: RUN_LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clr) begin
         cnt_d = '0;
      end else if (inc && (cnt_q != CNT_MAX)) begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   // next increment completes (or a saturated count re-confirms) the run
   assign last_step = (cnt_q >= CNT_NEAR);

   assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

   assert_cnt_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt_q));

   assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/srv_mode_reg.sv
module srv_mode_reg
   import srv_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      toggle,
   input  logic      go_main,
   input  logic      go_pre,
   output srv_mode_e mode
);
   srv_mode_e mode_d;

   always_comb begin
      mode_d = mode;
      if (toggle) begin
         mode_d = mode_flip(mode);
      end else if (mode == MODE_PRE && go_main) begin
         mode_d = MODE_MAIN;
      end else if (mode == MODE_MAIN && go_pre) begin
         mode_d = MODE_PRE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= RESET_MODE;
      end else begin
         mode <= mode_d;
      end
   end

   assert_toggle_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      toggle |=> (mode != $past(mode)));

endmodule

// File: rtl/srv_mode_hyst.sv
module srv_mode_hyst
   import srv_mode_pkg::*;
#(
   parameter int unsigned ENTER_RUN = 16,
   parameter int unsigned LEAVE_RUN = 64,
   parameter bit          CMD_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_tick,
   input  logic lock_n,
   input  logic host_cmd,
   output logic mode_pre
);
   if (ENTER_RUN < 1 || LEAVE_RUN < 1) begin : g_bad_runs
      $error("srv_mode_hyst: run lengths must be at least 1");
   end

   logic cmd_pulse;

   if (CMD_LEVEL) begin : g_cmd_edge
      logic cmd_prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmd_prev_q <= 1'b0;
         end else begin
            cmd_prev_q <= host_cmd;
         end
      end
      assign cmd_pulse = host_cmd & ~cmd_prev_q;
   end else begin : g_cmd_strobe
      assign cmd_pulse = host_cmd;
   end

   logic step;
   logic locked_frame;
   logic unlocked_frame;
   logic lo_last;
   logic hi_last;
   logic go_main;
   logic go_pre;
   srv_mode_e mode_q;

   assign step           = frame_tick & ~cmd_pulse;
   assign locked_frame   = step & ~lock_n;
   assign unlocked_frame = step & lock_n;

   srv_run_cnt #(.RUN_LEN(ENTER_RUN)) u_lo_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cmd_pulse | unlocked_frame),
      .inc       (locked_frame),
      .last_step (lo_last)
   );

   srv_run_cnt #(.RUN_LEN(LEAVE_RUN)) u_hi_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cmd_pulse | locked_frame),
      .inc       (unlocked_frame),
      .last_step (hi_last)
   );

   assign go_main = locked_frame & lo_last;
   assign go_pre  = unlocked_frame & hi_last;

   srv_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .toggle  (cmd_pulse),
      .go_main (go_main),
      .go_pre  (go_pre),
      .mode    (mode_q)
   );

   assign mode_pre = (mode_q == MODE_PRE);

   assert_fall_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_pre) |-> $past(frame_tick || cmd_pulse));

   assert_rise_on_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_pre) |-> $past(frame_tick || cmd_pulse));

   assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_tick && !cmd_pulse) |=> $stable(mode_pre));

   assert_unlocked_no_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_pulse && lock_n) |=> !$fell(mode_pre));

   assert_locked_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_pulse && !lock_n) |=> !$rose(mode_pre));

endmodule

// File: tb/tb_srv_mode_hyst.sv
module tb_srv_mode_hyst;
   localparam int ENTER_N = 16;
   localparam int LEAVE_N = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_tick = 1'b0;
   logic lock_n = 1'b1;
   logic host_cmd = 1'b0;
   logic mode_pre;

   int checks = 0;
   int fails = 0;
   string phase_req = "R1";

   // behavioural reference
   bit ref_mode = 1'b1;
   int ref_lo = 0;
   int ref_hi = 0;

   always #2.5 clk = ~clk;

   srv_mode_hyst dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .lock_n     (lock_n),
      .host_cmd   (host_cmd),
      .mode_pre   (mode_pre)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         ref_mode = 1'b1; ref_lo = 0; ref_hi = 0;
      end else if (host_cmd) begin
         ref_mode = !ref_mode; ref_lo = 0; ref_hi = 0;
      end else if (frame_tick) begin
         if (!lock_n) begin
            ref_lo++; ref_hi = 0;
            if (ref_mode && ref_lo >= ENTER_N) ref_mode = 1'b0;
         end else begin
            ref_hi++; ref_lo = 0;
            if (!ref_mode && ref_hi >= LEAVE_N) ref_mode = 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (mode_pre !== ref_mode) begin
            fails++;
            $display("FAIL %s model compare: mode_pre=%0b expected %0b at %0t",
                     phase_req, mode_pre, ref_mode, $time);
         end
      end
   end

   task automatic check_mode(input bit exp, input string req, input string what);
      checks++;
      if (mode_pre !== exp) begin
         fails++;
         $display("FAIL %s %s: mode_pre=%0b expected %0b", req, what, mode_pre, exp);
      end
   endtask

   // n frames at level lvl, each followed by gap idle cycles (lock_n toggled while idle)
   task automatic frames(input bit lvl, input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_tick = 1'b1; lock_n = lvl;
         @(negedge clk);
         frame_tick = 1'b0;
         for (int g = 0; g < gap; g++) begin
            lock_n = ~lvl;
            @(negedge clk);
         end
         lock_n = lvl;
      end
   endtask

   task automatic pulse_cmd(input bit with_tick, input bit lvl);
      @(negedge clk);
      host_cmd = 1'b1; frame_tick = with_tick; lock_n = lvl;
      @(negedge clk);
      host_cmd = 1'b0; frame_tick = 1'b0;
   endtask

   initial begin
      #(5ns * 150000);
      fails++;
      $display("FAIL watchdog expired in phase %s", phase_req);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check_mode(1'b1, "R1", "during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_mode(1'b1, "R1", "after reset");

      phase_req = "R2";
      frames(1'b0, ENTER_N - 1, 2);
      check_mode(1'b1, "R2", "one locked frame short");
      frames(1'b0, 1, 0);
      check_mode(1'b0, "R2", "locked run complete");

      phase_req = "R3";
      frames(1'b1, LEAVE_N - 1, 1);
      check_mode(1'b0, "R3", "one unlocked frame short");
      frames(1'b1, 1, 0);
      check_mode(1'b1, "R3", "unlocked run complete");

      phase_req = "R4";
      frames(1'b0, 10, 0);
      frames(1'b1, 1, 0);
      frames(1'b0, ENTER_N - 1, 0);
      check_mode(1'b1, "R4", "broken locked run restarts");
      frames(1'b0, 1, 0);
      check_mode(1'b0, "R4", "restarted run completes");
      frames(1'b1, 40, 0);
      frames(1'b0, 1, 0);
      frames(1'b1, LEAVE_N - 1, 0);
      check_mode(1'b0, "R4", "broken unlocked run restarts");

      phase_req = "R5";
      lock_n = 1'b1;
      repeat (200) @(negedge clk);
      check_mode(1'b0, "R5", "no strobe, unlocked level held");
      frames(1'b1, 1, 0);
      check_mode(1'b1, "R5", "counted strobe finishes run");
      frames(1'b0, ENTER_N - 1, 5);
      lock_n = 1'b0;
      repeat (100) @(negedge clk);
      check_mode(1'b1, "R5", "no strobe, locked level held");

      phase_req = "R6";
      pulse_cmd(1'b0, 1'b1);
      check_mode(1'b0, "R6", "command toggles to main");
      pulse_cmd(1'b1, 1'b1);
      check_mode(1'b1, "R6", "command beats strobe");
      frames(1'b0, 10, 0);
      pulse_cmd(1'b1, 1'b0);
      check_mode(1'b0, "R6", "command mid run");
      pulse_cmd(1'b0, 1'b0);
      frames(1'b0, ENTER_N - 1, 0);
      check_mode(1'b1, "R6", "run cleared by command");
      frames(1'b0, 1, 0);
      check_mode(1'b0, "R6", "fresh run completes");

      phase_req = "R7";
      frames(1'b0, 300, 0);
      check_mode(1'b0, "R7", "long locked run");
      frames(1'b1, LEAVE_N - 1, 0);
      check_mode(1'b0, "R7", "unlocked after saturation, short");
      frames(1'b1, 1, 0);
      check_mode(1'b1, "R7", "unlocked after saturation, complete");
      frames(1'b1, 500, 0);
      check_mode(1'b1, "R7", "long unlocked run");
      frames(1'b0, ENTER_N, 0);
      check_mode(1'b0, "R7", "locked after saturation");

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule